// File: doc/BRIEF.md
# Byte-Lane Memory over Word Storage

This block offers a memory that software and neighbouring logic address one byte at a time, while the bits themselves live in a single array of wider words. In the full configuration, 64K byte locations are mapped onto 16K words of 32 bits, so no capacity is gained or lost. The storage array is used as one indivisible unit. It has one index, one word-wide data input, one word-wide data output and one write strobe.

The incoming byte address is split. The upper bits pick a word, and the two lowest bits pick one of the four byte lanes in that word. A read is purely combinational: the output always shows the byte at the current address, and there is no read strobe. A write merges the new byte into the word that is currently stored, within the same cycle, and then stores the whole word back on the rising clock edge. The other three lanes therefore leave the array exactly as they went in.

The data pins are plain signals with no valid/ready handshake. A write is accepted in every cycle that has the write enable high, and a read result is available in every cycle, so there is never any back-pressure. The address width is a parameter. It defaults to 10 bits so that the default build stays small, and it is set to 16 for the 64K arrangement.

Top module: `byteram_wordback`

## Requirements
- R1: The block holds 2**ADDR_W independent byte locations, built on 2**(ADDR_W-2) stored words of four 8-bit lanes each. Every byte address can be written and read back on its own.
- R2: rd_data shows the byte at the present addr combinationally. It follows any change of addr without a clock edge and without any strobe.
- R3: When we is 1 at a rising clock edge, the byte on wr_data is stored at addr. From the next cycle on, a read of that address returns it.
- R4: A write changes only the addressed byte. The other three byte addresses that share its word (the same addr with only the lowest two bits different) keep their previous values.
- R5: While we is 0, no stored byte changes, and with addr held steady rd_data holds steady.
- R6: A write to one word leaves every other word unchanged.
- R7: Writes on consecutive cycles to different lanes of one word are all kept. Consecutive writes to the same address leave the last value.
- R8: During the cycle in which a write is presented, rd_data at that address still shows the old contents. The new byte appears only after the edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes happen on its rising edge |
| we | input | 1 | Write enable, active high |
| addr | input | ADDR_W | Byte address for both read and write |
| wr_data | input | 8 | Byte to store |
| rd_data | output | 8 | Byte stored at addr, combinational |

## Verification
The combinational read of a word and the write of that same word happen in the same cycle. The merge uses the word that is currently stored, so a write to one lane immediately after a write to a neighbouring lane must see the first update. The bench provokes this with unbroken runs of writes, one to each lane of a word, and then reads all four bytes against a byte-granular model. It also samples rd_data while a write is still pending, to confirm that the old byte is shown until the edge.

// File: rtl/byteram_pkg.sv
package byteram_pkg;
  localparam int BYTE_BITS   = 8;
  localparam int WORD_LANES  = 4;
  localparam int ADDR_BITS_D = 10;
endpackage

// File: rtl/byteram_addr_split.sv
module byteram_addr_split #(
  parameter int ADDR_W = 10,
  parameter int SEL_W  = 2,
  localparam int IDX_W = ADDR_W - SEL_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  word_idx,
  output logic [SEL_W-1:0]  lane_sel
);
  assign word_idx = addr[ADDR_W-1:SEL_W];
  assign lane_sel = addr[SEL_W-1:0];
endmodule

// File: rtl/byteram_lane_merge.sv
module byteram_lane_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int SEL_W  = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [LANE_W-1:0] byte_in,
  input  logic [SEL_W-1:0]  lane_sel,
  output logic [WORD_W-1:0] word_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign word_out[g*LANE_W +: LANE_W] =
      (lane_sel == SEL_W'(g)) ? byte_in : word_in[g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/byteram_lane_pick.sv
module byteram_lane_pick #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int SEL_W  = $clog2(LANES),
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic [WORD_W-1:0] word_in,
  input  logic [SEL_W-1:0]  lane_sel,
  output logic [LANE_W-1:0] byte_out
);
  logic [LANE_W-1:0] lanes [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_split
    assign lanes[g] = word_in[g*LANE_W +: LANE_W];
  end

  assign byte_out = lanes[lane_sel];
endmodule

// File: rtl/byteram_word_store.sv
module byteram_word_store #(
  parameter int IDX_W  = 8,
  parameter int WORD_W = 32,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORD_W-1:0] din,
  input  logic              wen,
  output logic [WORD_W-1:0] dout
);
  logic [WORD_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wen) cells[idx] <= din;
  end

  assign dout = cells[idx];
endmodule

// File: rtl/byteram_wordback.sv
module byteram_wordback #(
  parameter int ADDR_W = byteram_pkg::ADDR_BITS_D,
  parameter int LANE_W = byteram_pkg::BYTE_BITS,
  parameter int LANES  = byteram_pkg::WORD_LANES,
  localparam int SEL_W  = $clog2(LANES),
  localparam int IDX_W  = ADDR_W - SEL_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANE_W-1:0] wr_data,
  output logic [LANE_W-1:0] rd_data
);
  logic [IDX_W-1:0]  word_idx;
  logic [SEL_W-1:0]  lane_sel;
  logic [WORD_W-1:0] store_word;
  logic [WORD_W-1:0] merged_word;

  byteram_addr_split #(.ADDR_W(ADDR_W), .SEL_W(SEL_W)) split_i (
    .addr     (addr),
    .word_idx (word_idx),
    .lane_sel (lane_sel)
  );

  byteram_word_store #(.IDX_W(IDX_W), .WORD_W(WORD_W)) store_i (
    .clk  (clk),
    .idx  (word_idx),
    .din  (merged_word),
    .wen  (we),
    .dout (store_word)
  );

  byteram_lane_merge #(.LANES(LANES), .LANE_W(LANE_W)) merge_i (
    .word_in  (store_word),
    .byte_in  (wr_data),
    .lane_sel (lane_sel),
    .word_out (merged_word)
  );

  byteram_lane_pick #(.LANES(LANES), .LANE_W(LANE_W)) pick_i (
    .word_in  (store_word),
    .lane_sel (lane_sel),
    .byte_out (rd_data)
  );
endmodule

// File: rtl/byteram_checker.sv
module byteram_checker #(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  parameter int LANES  = 4,
  localparam int SEL_W  = $clog2(LANES),
  localparam int IDX_W  = ADDR_W - SEL_W,
  localparam int WORD_W = LANES * LANE_W
) (
  input logic              clk,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [LANE_W-1:0] wr_data,
  input logic [LANE_W-1:0] rd_data,
  input logic [IDX_W-1:0]  word_idx,
  input logic [SEL_W-1:0]  lane_sel,
  input logic [WORD_W-1:0] store_word
);
  logic armed  = 1'b0;
  logic armed2 = 1'b0;

  always_ff @(posedge clk) begin
    armed  <= 1'b1;
    armed2 <= armed;
  end

  logic [WORD_W-1:0] keep_mask;
  assign keep_mask = ~({{(WORD_W-LANE_W){1'b0}}, {LANE_W{1'b1}}} << (lane_sel * LANE_W));

  // R3: a written byte is read back at the same address in the next cycle
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!armed)
    we |=> (addr != $past(addr)) || (rd_data == $past(wr_data)));

  // R4: the three lanes outside the written one are preserved
  a_r4_other_lanes_kept: assert property (@(posedge clk) disable iff (!armed)
    we |=> (word_idx != $past(word_idx)) ||
           ((store_word & $past(keep_mask)) == ($past(store_word) & $past(keep_mask))));

  // R5: without a write the addressed word does not change
  a_r5_idle_word_kept: assert property (@(posedge clk) disable iff (!armed)
    !we |=> (word_idx != $past(word_idx)) || (store_word == $past(store_word)));

  // R5: steady address and no write gives a steady read
  a_r5_idle_read_steady: assert property (@(posedge clk) disable iff (!armed2)
    (!$past(we) && $stable(addr)) |-> $stable(rd_data));
endmodule

bind byteram_wordback byteram_checker #(
  .ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)
) chk_i (
  .clk        (clk),
  .we         (we),
  .addr       (addr),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .word_idx   (word_idx),
  .lane_sel   (lane_sel),
  .store_word (store_word)
);

// File: tb/byteram_wordback_tb.sv
`timescale 1ns/1ps
module byteram_wordback_tb_top;
  localparam int AW    = 10;
  localparam int NBYTE = 1 << AW;
  localparam int NWORD = NBYTE / 4;

  logic          clk = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wr_data = '0;
  logic [7:0]    rd_data;

  logic [7:0] model [NBYTE];
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byteram_wordback #(.ADDR_W(AW)) dut_i (
    .clk(clk), .we(we), .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d, input bit peek, input string req);
    @(negedge clk);
    we = 1'b1; addr = AW'(a); wr_data = d;
    #1;
    if (peek) check(rd_data == model[a], req, rd_data, model[a]);
    @(posedge clk);
    model[a] = d;
  endtask

  task automatic rd(input int a, input string req);
    @(negedge clk);
    we = 1'b0; addr = AW'(a);
    #1;
    check(rd_data == model[a], req, rd_data, model[a]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    // R1 R3: sweep every byte address with a computed pattern
    for (int a = 0; a < NBYTE; a++) wr(a, 8'((a * 37 + 5) ^ (a >> 8)), 0, "R3");
    for (int a = 0; a < NBYTE; a++) rd(a, "R1");

    // R4: write one lane, read all four lanes of the word
    for (int w = 0; w < NWORD; w += 17) begin
      for (int l = 0; l < 4; l++) begin
        wr(w*4 + l, 8'hA5 ^ 8'(l * 16 + w), 0, "R4");
        for (int k = 0; k < 4; k++) rd(w*4 + k, "R4");
      end
    end

    // R7 R8: back-to-back writes to every lane of a word, peeking old data
    for (int w = 3; w < NWORD; w += 29) begin
      for (int l = 0; l < 4; l++) wr(w*4 + l, 8'(8'h3C + l + w), 1, "R8");
      for (int k = 0; k < 4; k++) rd(w*4 + k, "R7");
    end

    // R7: repeated writes to one address, last value wins
    wr(77, 8'h11, 1, "R8");
    wr(77, 8'h22, 1, "R8");
    wr(77, 8'h33, 1, "R8");
    rd(77, "R7");
    rd(76, "R4");
    rd(78, "R4");

    // R2: read follows addr with no clock edge
    @(negedge clk);
    we = 1'b0;
    for (int a = 200; a < 208; a++) begin
      addr = AW'(a);
      #0.3;
      check(rd_data == model[a], "R2", rd_data, model[a]);
    end

    // R5: held address, no write, several edges
    rd(513, "R5");
    repeat (5) begin
      @(negedge clk);
      check(rd_data == model[513], "R5", rd_data, model[513]);
    end
    wr_data = 8'hFF;
    repeat (3) @(negedge clk);
    check(rd_data == model[513], "R5", rd_data, model[513]);

    // R3 R4 R6: interleaved pseudo-random operations
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) wr(int'(lfsr[15:6]), lfsr[7:0] ^ lfsr[15:8], 1, "R8");
      else rd(int'(lfsr[12:3]), "R6");
    end

    // R6: final sweep of all bytes
    for (int a = 0; a < NBYTE; a++) rd(a, "R6");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule